// File: doc/BRIEF.md
# Partitioned SIMD Left Shifter

This block shifts a wide data word left, with the word cut into equal lanes that can be grouped at run time. A control bit sits at each internal lane boundary. When the bit is set, the boundary separates two partitions. When it is clear, the lanes on both sides belong to one wider partition. Each partition moves its own slice of the data operand left by a count taken from the operand that holds the shift counts. Zeros enter at the bottom of the partition. Bits pushed past the top of the partition are dropped and never reach the partition above.

The block has no clock and no storage. The result follows the inputs in the same cycle, so the block can sit inside a SIMD execution stage that picks its lane size per instruction. The default build is 24 bits with three 8-bit lanes. The same code also builds 64 bits with eight 8-bit lanes.

Top module: `psimd_shl`

## Requirements
- R1: With every split bit clear, `res_o` equals `opa_i` shifted left by the unsigned value of `amt_i[LW-1:0]` and truncated to WIDTH bits. LW is WIDTH/LANES.
- R2: No bit crosses a set boundary. Result bits in a partition depend only on the slice of `opa_i` inside that partition.
- R3: The shift count of a partition is the unsigned LW-bit value of the lowest `amt_i` lane inside that partition. The `amt_i` lanes above it in the same partition have no effect on `res_o`.
- R4: Vacated low bits of each partition are filled with zeros.
- R5: A shift count equal to or greater than the width of the partition makes that whole partition of `res_o` zero.
- R6: A shift count of zero passes the partition's slice of `opa_i` through unchanged.
- R7: Split bit k controls the boundary at bit (k+1)*LW, so bit 0 is the lowest boundary. A value of 1 splits the word there and 0 joins the two lanes.
- R8: The block is combinational. `res_o` reflects new inputs without any clock edge, and all-zero inputs give an all-zero result.
- R9: With every split bit set, each LW-bit lane i of `res_o` is lane i of `opa_i` shifted by lane i of `amt_i`, truncated to LW bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Data word to be shifted |
| amt_i | input | WIDTH | Shift counts, one unsigned LW-bit count per lane |
| split_i | input | LANES-1 | Boundary controls, bit k at bit (k+1)*LW, 1 = split |
| res_o | output | WIDTH | Shifted result |

## Verification
If the head-lane map is wrong, whole upper lanes show up shifted by the count of the wrong lane, or carry bits across a boundary that should hold them back. This shows in the same evaluation as the bad split pattern. If a candidate shifter is wrong, every lane picked from it is wrong, and the error is clearest at the edge counts: zero, the partition width minus one, and the partition width. The sweep drives all split patterns with these edge counts and with unused upper count lanes filled with noise, so that a count taken from the wrong lane changes the result.

// File: rtl/psh_pkg.sv
`timescale 1ns/1ps
package psh_pkg;
    parameter int unsigned DEF_WIDTH = 24;
    parameter int unsigned DEF_LANES = 3;

    // Width of an index that names one lane (at least one bit).
    function automatic int unsigned lane_idx_w(input int unsigned lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction
endpackage

// File: rtl/psh_part_map.sv
`timescale 1ns/1ps
// Works out, for every lane, which lane is the lowest one of its partition.
module psh_part_map #(
    parameter int unsigned LANES = psh_pkg::DEF_LANES,
    localparam int unsigned IW   = psh_pkg::lane_idx_w(LANES)
) (
    input  logic [LANES-2:0]         split,
    output logic [LANES-1:0][IW-1:0] head
);
    logic [LANES-1:0][IW-1:0] head_d;

    always_comb begin
        head_d[0] = '0;
        for (int l = 1; l < LANES; l++) begin
            if (split[l-1]) head_d[l] = IW'(l);
            else            head_d[l] = head_d[l-1];
        end
    end

    assign head = head_d;

    // A lane just above a set boundary leads its own partition; below a clear one it shares.
    for (genvar l = 1; l < LANES; l++) begin : g_chk
        always_comb begin
            if (!$isunknown(split)) begin
                AST_HEAD_BELOW_SELF: assert (32'(head[l]) <= l)
                    else $error("head lane above lane %0d", l); // R7
                AST_HEAD_ORDERED: assert (head[l] >= head[l-1])
                    else $error("head lanes out of order at %0d", l); // R2
            end
        end
    end
endmodule

// File: rtl/psh_lane_shift.sv
`timescale 1ns/1ps
// Candidate result for a partition whose lowest lane is START.
module psh_lane_shift #(
    parameter int unsigned WIDTH = psh_pkg::DEF_WIDTH,
    parameter int unsigned LW    = 8,
    parameter int unsigned START = 0,
    localparam int unsigned LO   = START * LW
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [LW-1:0]    amt,
    output logic [WIDTH-1:0] res
);
    localparam logic [WIDTH-1:0] KEEP = ~((WIDTH'(1) << LO) - WIDTH'(1));

    logic [WIDTH-1:0] masked_d;
    logic [WIDTH-1:0] res_d;

    always_comb begin
        masked_d = opa & KEEP;
        if (32'(amt) >= 32'(WIDTH - LO)) res_d = '0;
        else                             res_d = masked_d << amt;
    end

    assign res = res_d;

    always_comb begin
        if (!$isunknown({opa, amt})) begin
            AST_NO_BIT_GAIN: assert ($countones(res) <= $countones(opa))
                else $error("shifter %0d invented bits", START); // R4
        end
    end
endmodule

// File: rtl/psh_lane_pick.sv
`timescale 1ns/1ps
// Each output lane takes its slice from the candidate of its head lane.
module psh_lane_pick #(
    parameter int unsigned WIDTH = psh_pkg::DEF_WIDTH,
    parameter int unsigned LANES = psh_pkg::DEF_LANES,
    localparam int unsigned LW   = WIDTH / LANES,
    localparam int unsigned IW   = psh_pkg::lane_idx_w(LANES)
) (
    input  logic [LANES-1:0][WIDTH-1:0] cand,
    input  logic [LANES-1:0][IW-1:0]    head,
    output logic [WIDTH-1:0]            res
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [WIDTH-1:0] src_d;
        assign src_d = cand[head[l]];
        assign res[l*LW +: LW] = src_d[l*LW +: LW];
    end
endmodule

// File: rtl/psimd_shl.sv
`timescale 1ns/1ps
module psimd_shl #(
    parameter int unsigned WIDTH = psh_pkg::DEF_WIDTH,
    parameter int unsigned LANES = psh_pkg::DEF_LANES,
    localparam int unsigned LW   = WIDTH / LANES,
    localparam int unsigned IW   = psh_pkg::lane_idx_w(LANES)
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] amt_i,
    input  logic [LANES-2:0] split_i,
    output logic [WIDTH-1:0] res_o
);
    logic [LANES-1:0][IW-1:0]    head;
    logic [LANES-1:0][WIDTH-1:0] cand;

    psh_part_map #(.LANES(LANES)) u_map (
        .split (split_i),
        .head  (head)
    );

    for (genvar s = 0; s < LANES; s++) begin : g_shift
        psh_lane_shift #(.WIDTH(WIDTH), .LW(LW), .START(s)) u_shift (
            .opa (opa_i),
            .amt (amt_i[s*LW +: LW]),
            .res (cand[s])
        );
    end

    psh_lane_pick #(.WIDTH(WIDTH), .LANES(LANES)) u_pick (
        .cand (cand),
        .head (head),
        .res  (res_o)
    );

    // Per-lane checks relating the result to the inputs.
    for (genvar l = 0; l < LANES; l++) begin : g_chk
        logic [LW-1:0] hamt;
        logic [LW-1:0] out_l;
        logic [LW-1:0] in_l;
        logic [LW-1:0] lowm;
        int unsigned   off;

        assign hamt  = amt_i[32'(head[l])*LW +: LW];
        assign out_l = res_o[l*LW +: LW];
        assign in_l  = opa_i[l*LW +: LW];
        assign lowm  = ~({LW{1'b1}} << hamt);
        assign off   = l - 32'(head[l]);

        always_comb begin
            if (!$isunknown({opa_i, amt_i, split_i})) begin
                if (32'(hamt) >= (off + 1) * LW)
                    AST_OVERSHIFT_ZERO: assert (out_l == '0)
                        else $error("lane %0d not cleared", l); // R5
                if (hamt == '0)
                    AST_ZERO_AMT_PASS: assert (out_l == in_l)
                        else $error("lane %0d not passed", l); // R6
                if (off == 0 && 32'(hamt) < LW)
                    AST_LOW_ZERO_FILL: assert ((out_l & lowm) == '0)
                        else $error("lane %0d low fill", l); // R4
            end
        end
    end
endmodule

// File: tb/psimd_shl_bench.sv
`timescale 1ns/1ps
module psimd_shl_bench;
    localparam int W  = 24;
    localparam int N  = 3;
    localparam int LW = W / N;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic [W-1:0]  a, b, y;
    logic [N-2:0]  g;
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    psimd_shl #(.WIDTH(W), .LANES(N)) u_psimd_shl (
        .opa_i   (a),
        .amt_i   (b),
        .split_i (g),
        .res_o   (y)
    );

    function automatic logic [63:0] msk(input int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    // Reference: walk partitions, shift each one on its own.
    function automatic logic [W-1:0] model(input logic [W-1:0] av, input logic [W-1:0] bv,
                                           input logic [N-2:0] gv);
        logic [63:0] acc;
        int lo;
        acc = '0;
        lo  = 0;
        for (int l = 1; l <= N; l++) begin
            if (l == N || gv[l-1]) begin
                int hi;
                int pw;
                logic [63:0] part;
                logic [63:0] s;
                hi   = l * LW;
                pw   = hi - lo;
                part = (64'(av) >> lo) & msk(pw);
                s    = (64'(bv) >> lo) & msk(LW);
                if (s < 64'(pw)) acc = acc | (((part << s) & msk(pw)) << lo);
                lo = hi;
            end
        end
        return acc[W-1:0];
    endfunction

    task automatic check(input string tag, input logic [W-1:0] exp);
        #1;
        n_chk++;
        if (y !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (a=%h b=%h g=%b)", tag, y, exp, a, b, g);
        end
    endtask

    task automatic apply(input string tag, input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic [N-2:0] gv);
        @(negedge clk);
        a = av; b = bv; g = gv;
        check(tag, model(av, bv, gv));
    endtask

    function automatic logic [LW-1:0] pick_amt(input int k);
        case (k)
            0: return 8'd0;
            1: return 8'd7;
            2: return 8'd8;
            3: return 8'd15;
            4: return 8'd16;
            5: return 8'd23;
            6: return 8'd24;
            7: return 8'd255;
            8: return LW'($urandom_range(0, 7));
            default: return LW'($urandom_range(0, 31));
        endcase
    endfunction

    initial begin
        rst_n = 1'b0;
        a = '0; b = '0; g = '0;
        @(negedge clk);
        check("R8 idle zero", '0);
        rst_n = 1'b1;

        // R1 whole-word shifts at the edges
        apply("R1 shift 23", 24'h000001, 24'd23, 2'b00);
        check("R1 shift 23 value", 24'h800000);
        apply("R1 R5 shift 24", 24'hFFFFFF, 24'd24, 2'b00);
        check("R5 full width clears", 24'h000000);
        apply("R1 R6 shift 0", 24'hA5C3E1, 24'd0, 2'b00);
        check("R6 pass", 24'hA5C3E1);

        // R7 boundary order: bit 0 at bit 8, bit 1 at bit 16
        apply("R7 low split", 24'h0000FF, 24'h000001, 2'b01);
        check("R7 R2 low lane keeps carry", 24'h0000FE);
        apply("R7 high split", 24'h0000FF, 24'h000001, 2'b10);
        check("R7 merged low 16", 24'h0001FE);
        apply("R2 no cross high", 24'h00FF00, 24'h000100, 2'b01);
        check("R2 top drops", 24'h01FE00);
        apply("R2 R9 lane tops", 24'h808080, 24'h010101, 2'b11);
        check("R9 all lanes drop", 24'h000000);

        // R3 upper count lanes ignored inside a merged partition
        apply("R3 base", 24'h123456, 24'h000004, 2'b00);
        check("R3 base value", 24'h234560);
        apply("R3 noisy upper", 24'h123456, 24'hFFEE04, 2'b00);
        check("R3 noisy value", 24'h234560);
        apply("R3 split16 noise", 24'h123456, 24'h00FF03, 2'b10);

        // R8 change inputs away from any edge
        @(posedge clk);
        #1;
        a = 24'h000003; b = 24'h000002; g = 2'b11;
        check("R8 no clock", 24'h00000C);

        // Sweep every split pattern with edge and random counts (R4 R5 R6 R9)
        for (int gv = 0; gv < (1 << (N - 1)); gv++) begin
            for (int t = 0; t < 300; t++) begin
                logic [W-1:0] bv;
                string tag;
                for (int l = 0; l < N; l++) bv[l*LW +: LW] = pick_amt($urandom_range(0, 9));
                if (gv == 0) tag = "R1 R4 R5 sweep";
                else if (gv == (1 << (N - 1)) - 1) tag = "R9 R4 R5 sweep";
                else tag = "R2 R3 R6 sweep";
                apply(tag, W'($urandom), bv, (N-1)'(gv));
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule